// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, each cycle, how the front and middle of a five-stage in-order pipeline move. It watches the instruction in the execute stage and the one in decode. When a load in execute writes a register that the decode instruction reads, it freezes fetch and decode for one cycle and puts a bubble into execute. Branches are resolved in decode under a predict-not-taken policy. A taken branch discards only the single instruction fetched behind it and steers the next fetch to the branch target.

An exception raised in execute has two possible sources: arithmetic overflow, or an undefined instruction whose flag has been carried down to execute. On such an exception the block empties the three stage registers behind the faulting point and steers fetch to a fixed handler vector. It also records the execute-stage PC and a cause code, and both values hold until the next exception. All steering outputs are combinational from the current cycle's inputs. Only the exception PC and cause registers hold state.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_dst_reg` equals `id_src_a`, and no branch or exception is active, `pc_write` and `ifid_write` are 0, `idex_zero` is 1, `pc_sel` is 0 (sequential) and no flush output is asserted.
- R2: The same stall happens when `ex_dst_reg` equals `id_src_b`. No stall happens when `ex_is_load` is 0, or when neither source matches; all enables then stay 1.
- R3: When `id_branch_taken` is 1 and no exception is active, `ifid_flush` is 1, `pc_sel` is 1 (branch target), `pc_write` and `ifid_write` are 1, and `idex_zero` and `exmem_flush` are 0.
- R4: When `ex_overflow` or `ex_undef` is 1, `ifid_flush`, `idex_zero` and `exmem_flush` are all 1, `pc_sel` is 2 (handler vector) and `pc_write` is 1.
- R5: `exc_vector` always equals the parameter `HANDLER_ADDR`, which defaults to 32'h8000_0180.
- R6: On a clock edge where an exception is active, `epc` loads `ex_pc`. It holds its value on every other edge.
- R7: `cause` loads 1 on overflow and 2 on an undefined instruction, and overflow wins when both are present. It holds on edges without an exception.
- R8: Priority is exception, then taken branch, then load-use stall. A lower-priority condition has no effect on the outputs while a higher one is active.
- R9: After reset, `epc` is 0 and `cause` is 0 (none).
- R10: With no load-use match, no branch and no exception, `pc_write` and `ifid_write` are 1, all flush and zero outputs are 0, and `pc_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| ex_dst_reg | input | 5 | Load destination register in execute |
| id_src_a | input | 5 | First source register of decode instruction |
| id_src_b | input | 5 | Second source register of decode instruction |
| id_branch_taken | input | 1 | Branch resolved taken in decode |
| ex_overflow | input | 1 | Arithmetic overflow in execute |
| ex_undef | input | 1 | Undefined instruction reached execute |
| ex_pc | input | 32 | PC of the instruction in execute |
| pc_write | output | 1 | PC register load enable |
| ifid_write | output | 1 | Fetch/decode register load enable |
| ifid_flush | output | 1 | Clear fetch/decode register |
| idex_zero | output | 1 | Zero control bits written into decode/execute register |
| exmem_flush | output | 1 | Clear execute/memory register |
| pc_sel | output | 2 | Next-PC select: 0 sequential, 1 branch target, 2 handler |
| exc_vector | output | 32 | Handler address for the PC mux |
| epc | output | 32 | Captured exception PC |
| cause | output | 2 | Captured cause: 0 none, 1 overflow, 2 undefined |

## Verification
The interesting collisions come from several conditions arriving in one cycle. One case is a taken branch in decode that also reads the register a load in execute is producing. Another is an overflow in execute while a branch in decode resolves taken and a load-use match is present. The bench drives these combinations in a single cycle. It judges the outcome by comparing every steering output with a priority model it computes itself: the branch must win over the stall, and the exception must win over both. It also checks that the captured PC and cause come from the exception and not from the lower-priority events.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [1:0] {
    PCSRC_SEQ    = 2'd0,
    PCSRC_BRANCH = 2'd1,
    PCSRC_VECTOR = 2'd2
  } pc_src_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_OVF   = 2'd1,
    CAUSE_UNDEF = 2'd2
  } cause_e;

  // Overflow outranks undefined instruction when both are flagged.
  function automatic cause_e pick_cause(input logic ovf, input logic undef);
    if (ovf)        return CAUSE_OVF;
    else if (undef) return CAUSE_UNDEF;
    else            return CAUSE_NONE;
  endfunction

  // A load-use match on any one of the read sources.
  function automatic logic any_match(input logic [7:0] hits, input int n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < n && i < 8; i++) r = r | hits[i];
    return r;
  endfunction

endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse #(
  parameter int RID_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            ld_in_ex,
  input  logic [RID_W-1:0]                ld_dst,
  input  logic [NUM_SRC-1:0][RID_W-1:0]   src_ids,
  output logic                            hit
);
  import hzc_pkg::*;

  localparam int HW = 8;
  logic [HW-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < HW; gi++) begin : g_cmp
      if (gi < NUM_SRC) begin : g_live
        assign match[gi] = (src_ids[gi] == ld_dst);
      end else begin : g_pad
        assign match[gi] = 1'b0;
      end
    end
  endgenerate

  assign hit = ld_in_ex & any_match(match, NUM_SRC);

endmodule

// File: rtl/hzc_priority.sv
module hzc_priority (
  input  logic            exc_take,
  input  logic            br_take,
  input  logic            lu_hit,
  output logic            pc_write,
  output logic            ifid_write,
  output logic            ifid_flush,
  output logic            idex_zero,
  output logic            exmem_flush,
  output hzc_pkg::pc_src_e pc_sel
);
  import hzc_pkg::*;

  always_comb begin
    pc_write    = 1'b1;
    ifid_write  = 1'b1;
    ifid_flush  = 1'b0;
    idex_zero   = 1'b0;
    exmem_flush = 1'b0;
    pc_sel      = PCSRC_SEQ;
    if (exc_take) begin
      ifid_flush  = 1'b1;
      idex_zero   = 1'b1;
      exmem_flush = 1'b1;
      pc_sel      = PCSRC_VECTOR;
    end else if (br_take) begin
      ifid_flush  = 1'b1;
      pc_sel      = PCSRC_BRANCH;
    end else if (lu_hit) begin
      pc_write    = 1'b0;
      ifid_write  = 1'b0;
      idex_zero   = 1'b1;
    end
  end

endmodule

// File: rtl/hzc_exc_capture.sv
module hzc_exc_capture #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf,
  input  logic            undef,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] epc,
  output hzc_pkg::cause_e cause
);
  import hzc_pkg::*;

  logic take;
  assign take = ovf | undef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= CAUSE_NONE;
    end else if (take) begin
      epc   <= pc_in;
      cause <= pick_cause(ovf, undef);
    end
  end

  // R7
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cause == CAUSE_OVF);

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause));

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int              PC_W         = 32,
  parameter int              RID_W        = 5,
  parameter logic [PC_W-1:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_is_load,
  input  logic [RID_W-1:0] ex_dst_reg,
  input  logic [RID_W-1:0] id_src_a,
  input  logic [RID_W-1:0] id_src_b,
  input  logic             id_branch_taken,
  input  logic             ex_overflow,
  input  logic             ex_undef,
  input  logic [PC_W-1:0]  ex_pc,
  output logic             pc_write,
  output logic             ifid_write,
  output logic             ifid_flush,
  output logic             idex_zero,
  output logic             exmem_flush,
  output logic [1:0]       pc_sel,
  output logic [PC_W-1:0]  exc_vector,
  output logic [PC_W-1:0]  epc,
  output logic [1:0]       cause
);
  import hzc_pkg::*;

  localparam int NUM_SRC = 2;

  logic                          exc_take;
  logic                          br_take;
  logic                          lu_hit;
  logic [NUM_SRC-1:0][RID_W-1:0] srcs;
  pc_src_e                       sel_w;
  cause_e                        cause_w;

  assign exc_take = ex_overflow | ex_undef;
  assign br_take  = id_branch_taken;
  assign srcs     = {id_src_b, id_src_a};

  hzc_loaduse #(.RID_W(RID_W), .NUM_SRC(NUM_SRC)) u_lu (
    .ld_in_ex (ex_is_load),
    .ld_dst   (ex_dst_reg),
    .src_ids  (srcs),
    .hit      (lu_hit)
  );

  hzc_priority u_pri (
    .exc_take    (exc_take),
    .br_take     (br_take),
    .lu_hit      (lu_hit),
    .pc_write    (pc_write),
    .ifid_write  (ifid_write),
    .ifid_flush  (ifid_flush),
    .idex_zero   (idex_zero),
    .exmem_flush (exmem_flush),
    .pc_sel      (sel_w)
  );

  hzc_exc_capture #(.PC_W(PC_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .ovf   (ex_overflow),
    .undef (ex_undef),
    .pc_in (ex_pc),
    .epc   (epc),
    .cause (cause_w)
  );

  assign pc_sel     = sel_w;
  assign cause      = cause_w;
  assign exc_vector = HANDLER_ADDR;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst_reg == id_src_a && !id_branch_taken && !exc_take)
      |-> (!pc_write && !ifid_write && idex_zero && !ifid_flush));

  // R3
  branch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch_taken && !exc_take)
      |-> (ifid_flush && !exmem_flush && !idex_zero && pc_sel == 2'd1));

  // R4
  exc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (ifid_flush && idex_zero && exmem_flush && pc_sel == 2'd2 && pc_write));

  // R6
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc == $past(ex_pc));

  // R6
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(epc));

  // R10
  front_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write == ifid_write);

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_is_load = 1'b0;
  logic [4:0]  ex_dst_reg = '0;
  logic [4:0]  id_src_a = '0;
  logic [4:0]  id_src_b = '0;
  logic        id_branch_taken = 1'b0;
  logic        ex_overflow = 1'b0;
  logic        ex_undef = 1'b0;
  logic [31:0] ex_pc = '0;
  logic        pc_write, ifid_write, ifid_flush, idex_zero, exmem_flush;
  logic [1:0]  pc_sel;
  logic [31:0] exc_vector, epc;
  logic [1:0]  cause;

  always #5 clk = ~clk;

  pipe_hazard_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst_reg(ex_dst_reg),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_branch_taken(id_branch_taken),
    .ex_overflow(ex_overflow), .ex_undef(ex_undef), .ex_pc(ex_pc),
    .pc_write(pc_write), .ifid_write(ifid_write), .ifid_flush(ifid_flush),
    .idex_zero(idex_zero), .exmem_flush(exmem_flush), .pc_sel(pc_sel),
    .exc_vector(exc_vector), .epc(epc), .cause(cause)
  );

  typedef struct {
    logic [6:0]  ctl;    // {pc_write, ifid_write, ifid_flush, idex_zero, exmem_flush, pc_sel}
    logic [31:0] epc;
    logic [1:0]  cause;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m_epc   = '0;
  logic [1:0]  m_cause = '0;

  task automatic drive(input logic ld, input logic [4:0] dst, input logic [4:0] sa,
                       input logic [4:0] sb, input logic br, input logic ovf,
                       input logic und, input logic [31:0] pc, input string tag);
    exp_t e;
    logic exc, hit;
    @(negedge clk);
    ex_is_load = ld; ex_dst_reg = dst; id_src_a = sa; id_src_b = sb;
    id_branch_taken = br; ex_overflow = ovf; ex_undef = und; ex_pc = pc;
    exc = ovf | und;
    hit = ld && ((dst == sa) || (dst == sb));
    if (exc) begin
      e.ctl = {5'b11111, 2'd2};
      m_epc = pc;
      m_cause = ovf ? 2'd1 : 2'd2;
    end else if (br)  e.ctl = {5'b11100, 2'd1};
    else if (hit)     e.ctl = {5'b00010, 2'd0};
    else              e.ctl = {5'b11000, 2'd0};
    e.epc = m_epc;
    e.cause = m_cause;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    logic [6:0] act;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        act = {pc_write, ifid_write, ifid_flush, idex_zero, exmem_flush, pc_sel};
        checks++;
        if (act !== e.ctl || epc !== e.epc || cause !== e.cause || exc_vector !== 32'h8000_0180) begin
          fails++;
          $display("FAIL %s: ctl=%b epc=%h cause=%0d vec=%h expected ctl=%b epc=%h cause=%0d vec=80000180",
                   e.tag, act, epc, cause, exc_vector, e.ctl, e.epc, e.cause);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    // R9: reset state
    checks++;
    if (epc !== 32'h0 || cause !== 2'd0) begin
      fails++;
      $display("FAIL R9 reset: epc=%h cause=%0d expected epc=0 cause=0", epc, cause);
    end
    rst_n = 1'b1;
    drive(0, 5'd0, 5'd1, 5'd2, 0, 0, 0, 32'h0,   "R10 idle R5 vector");
    drive(1, 5'd5, 5'd5, 5'd9, 0, 0, 0, 32'h10,  "R1 match src_a");
    drive(1, 5'd7, 5'd3, 5'd7, 0, 0, 0, 32'h14,  "R2 match src_b");
    drive(1, 5'd6, 5'd3, 5'd4, 0, 0, 0, 32'h18,  "R2 load no match");
    drive(0, 5'd3, 5'd3, 5'd3, 0, 0, 0, 32'h1c,  "R2 match without load");
    drive(0, 5'd0, 5'd1, 5'd2, 1, 0, 0, 32'h20,  "R3 taken branch");
    drive(1, 5'd8, 5'd8, 5'd1, 1, 0, 0, 32'h24,  "R8 branch beats stall");
    drive(0, 5'd0, 5'd1, 5'd2, 0, 1, 0, 32'h100, "R4 R6 R7 overflow");
    drive(0, 5'd0, 5'd1, 5'd2, 0, 0, 0, 32'h104, "R6 R7 hold after exception");
    drive(0, 5'd0, 5'd1, 5'd2, 0, 0, 1, 32'h204, "R4 R7 undefined");
    drive(0, 5'd0, 5'd1, 5'd2, 0, 1, 1, 32'h300, "R7 overflow over undefined");
    drive(1, 5'd4, 5'd4, 5'd4, 1, 0, 1, 32'h404, "R8 exception beats branch and stall");
    drive(1, 5'd2, 5'd9, 5'd9, 0, 0, 0, 32'h408, "R6 hold with idle load");
    drive(1, 5'd0, 5'd0, 5'd0, 0, 0, 0, 32'h40c, "R1 match both sources");
    drive(0, 5'd0, 5'd1, 5'd2, 0, 0, 0, 32'h410, "R10 resume");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule